// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

This block is a synchronous RAM with two ports, A and B. Each port has its own clock, enable, write enable, address, write data and read data. The ports share only the stored words. Everything a port samples is captured on its own clock edge. Its read register changes only on an enabled edge, so the output keeps the last result until that port performs another enabled operation.

Each port picks its read-during-write behaviour on every access with a two-bit mode input:
- 0 (old data): the output shows the word stored before the write.
- 1 (new data): the output shows the word being written.
- 2 or 3 (hold): the output keeps its previous value.

A per-port parameter adds an output pipeline register. That register advances only on enabled edges, so it costs one enabled cycle of latency.

Storage uses two banks, one clocked by each port. A word reads as the XOR of its two bank entries, so each register array is written from a single clock domain. A port's write updates only its own bank and returns the XOR to the value written.

Top module: `tdp_ram`

## Requirements
- R1: While rst_ni is low, rdata_a_o and rdata_b_o read 0 (including the pipeline register). Reset leaves the stored words unchanged, so a word written before reset reads back afterwards.
- R2: An enabled edge with write enable low loads the word at the port's address into the read register. With no output register it appears on the port's read data after that edge.
- R3: With the port enable low, an edge does not write memory and does not change any register of that port. The read data stays stable, even with write enable high.
- R4: In mode 0, a write stores the new word and the read data shows the word previously stored at that address.
- R5: In mode 1, a write stores the new word and the read data shows the written word.
- R6: In mode 2 or 3, a write stores the new word and the port's read register keeps its previous value.
- R7: With the port's OUT_REG parameter set to 1, the read register's value reaches the output on the next enabled edge. This adds exactly one enabled cycle of latency.
- R8: A word written through either port is read back unchanged through the other port.
- R9: When both ports write the same address on coincident edges, the word stored is port A's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of the port read registers |
| clk_a_i | input | 1 | Port A clock |
| en_a_i | input | 1 | Port A enable |
| we_a_i | input | 1 | Port A write enable |
| wmode_a_i | input | 2 | Port A read-during-write mode (0 old, 1 new, 2/3 hold) |
| addr_a_i | input | AW | Port A word address |
| wdata_a_i | input | WIDTH | Port A write data |
| rdata_a_o | output | WIDTH | Port A read data |
| clk_b_i | input | 1 | Port B clock |
| en_b_i | input | 1 | Port B enable |
| we_b_i | input | 1 | Port B write enable |
| wmode_b_i | input | 2 | Port B read-during-write mode (0 old, 1 new, 2/3 hold) |
| addr_b_i | input | AW | Port B word address |
| wdata_b_i | input | WIDTH | Port B write data |
| rdata_b_o | output | WIDTH | Port B read data |

## Verification
The bench builds the block with DEPTH=64 and WIDTH=16, OUT_REG_A=0 and OUT_REG_B=1. One instance therefore covers both the direct output path and the pipelined output path. Both port clocks are driven from one bench clock, which puts same-address writes on coincident edges and makes the port A priority rule observable. Cross-port reads of words written through the opposite bank check the XOR recombination.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic [1:0] {
    WM_OLD  = 2'd0,
    WM_NEW  = 2'd1,
    WM_HOLD = 2'd2
  } wmode_e;
endpackage

// File: rtl/tdp_ram_bank.sv
module tdp_ram_bank #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr0_i,
  input  logic [AW-1:0]    raddr1_i,
  output logic [WIDTH-1:0] rdata0_o,
  output logic [WIDTH-1:0] rdata1_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata0_o = mem_q[raddr0_i];
  assign rdata1_o = mem_q[raddr1_i];
endmodule

// File: rtl/tdp_ram_port.sv
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [1:0]       wmode_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] mem_word_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = mem_word_i;
    if (we_i) begin
      case (wmode_e'(wmode_i))
        WM_OLD:  rdata_d = mem_word_i;
        WM_NEW:  rdata_d = wdata_i;
        default: rdata_d = rdata_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (en_i) rdata_q <= rdata_d;
  end

  if (OUT_REG) begin : g_pipe
    logic [WIDTH-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pipe_q <= '0;
      else if (en_i) pipe_q <= rdata_q;
    end
    assign rdata_o = pipe_q;
  end else begin : g_direct
    assign rdata_o = rdata_q;
  end
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned WIDTH     = 16,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             rst_ni,
  input  logic             clk_a_i,
  input  logic             en_a_i,
  input  logic             we_a_i,
  input  logic [1:0]       wmode_a_i,
  input  logic [AW-1:0]    addr_a_i,
  input  logic [WIDTH-1:0] wdata_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic             clk_b_i,
  input  logic             en_b_i,
  input  logic             we_b_i,
  input  logic [1:0]       wmode_b_i,
  input  logic [AW-1:0]    addr_b_i,
  input  logic [WIDTH-1:0] wdata_b_i,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] a_at_a, a_at_b, b_at_a, b_at_b;
  logic [WIDTH-1:0] word_a, word_b;
  logic             wr_a, wr_b, clash;

  assign wr_a  = en_a_i & we_a_i;
  // same-address writes on a shared edge: port A wins
  assign clash = wr_a & en_b_i & we_b_i & (addr_a_i == addr_b_i);
  assign wr_b  = en_b_i & we_b_i & ~clash;

  // each bank stores wdata ^ other bank, so the XOR of both is the word
  tdp_ram_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank_a (
    .clk_i    (clk_a_i),
    .we_i     (wr_a),
    .waddr_i  (addr_a_i),
    .wdata_i  (wdata_a_i ^ b_at_a),
    .raddr0_i (addr_a_i),
    .raddr1_i (addr_b_i),
    .rdata0_o (a_at_a),
    .rdata1_o (a_at_b)
  );

  tdp_ram_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank_b (
    .clk_i    (clk_b_i),
    .we_i     (wr_b),
    .waddr_i  (addr_b_i),
    .wdata_i  (wdata_b_i ^ a_at_b),
    .raddr0_i (addr_a_i),
    .raddr1_i (addr_b_i),
    .rdata0_o (b_at_a),
    .rdata1_o (b_at_b)
  );

  assign word_a = a_at_a ^ b_at_a;
  assign word_b = a_at_b ^ b_at_b;

  tdp_ram_port #(.WIDTH(WIDTH), .OUT_REG(OUT_REG_A)) u_port_a (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .en_i       (en_a_i),
    .we_i       (we_a_i),
    .wmode_i    (wmode_a_i),
    .wdata_i    (wdata_a_i),
    .mem_word_i (word_a),
    .rdata_o    (rdata_a_o)
  );

  tdp_ram_port #(.WIDTH(WIDTH), .OUT_REG(OUT_REG_B)) u_port_b (
    .clk_i      (clk_b_i),
    .rst_ni     (rst_ni),
    .en_i       (en_b_i),
    .we_i       (we_b_i),
    .wmode_i    (wmode_b_i),
    .wdata_i    (wdata_b_i),
    .mem_word_i (word_b),
    .rdata_o    (rdata_b_o)
  );
endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_chk #(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned WIDTH     = 16,
  parameter bit          OUT_REG_A = 1'b0,
  parameter bit          OUT_REG_B = 1'b1,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic             rst_ni,
  input logic             clk_a_i,
  input logic             en_a_i,
  input logic             we_a_i,
  input logic [1:0]       wmode_a_i,
  input logic [AW-1:0]    addr_a_i,
  input logic [WIDTH-1:0] wdata_a_i,
  input logic [WIDTH-1:0] rdata_a_o,
  input logic             clk_b_i,
  input logic             en_b_i,
  input logic             we_b_i,
  input logic [1:0]       wmode_b_i,
  input logic [AW-1:0]    addr_b_i,
  input logic [WIDTH-1:0] wdata_b_i,
  input logic [WIDTH-1:0] rdata_b_o
);
  // R3
  freeze_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !en_a_i |=> $stable(rdata_a_o));
  // R3
  freeze_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !en_b_i |=> $stable(rdata_b_o));

  if (!OUT_REG_A) begin : g_a_direct
    // R5
    new_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (en_a_i && we_a_i && wmode_a_i == 2'd1) |=> rdata_a_o == $past(wdata_a_i));
    // R6
    hold_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (en_a_i && we_a_i && wmode_a_i[1]) |=> $stable(rdata_a_o));
  end else begin : g_a_pipe
    // R7
    new_a_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
      (en_a_i && we_a_i && wmode_a_i == 2'd1) ##1 en_a_i |=> rdata_a_o == $past(wdata_a_i, 2));
  end

  if (!OUT_REG_B) begin : g_b_direct
    // R5
    new_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      (en_b_i && we_b_i && wmode_b_i == 2'd1) |=> rdata_b_o == $past(wdata_b_i));
    // R6
    hold_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      (en_b_i && we_b_i && wmode_b_i[1]) |=> $stable(rdata_b_o));
  end else begin : g_b_pipe
    // R7
    new_b_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
      (en_b_i && we_b_i && wmode_b_i == 2'd1) ##1 en_b_i |=> rdata_b_o == $past(wdata_b_i, 2));
  end
endmodule

bind tdp_ram tdp_ram_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .OUT_REG_A(OUT_REG_A), .OUT_REG_B(OUT_REG_B)
) i_tdp_ram_chk (
  .rst_ni(rst_ni),
  .clk_a_i(clk_a_i), .en_a_i(en_a_i), .we_a_i(we_a_i), .wmode_a_i(wmode_a_i),
  .addr_a_i(addr_a_i), .wdata_a_i(wdata_a_i), .rdata_a_o(rdata_a_o),
  .clk_b_i(clk_b_i), .en_b_i(en_b_i), .we_b_i(we_b_i), .wmode_b_i(wmode_b_i),
  .addr_b_i(addr_b_i), .wdata_b_i(wdata_b_i), .rdata_b_o(rdata_b_o)
);

// File: tb/test_tdp_ram.sv
module test_tdp_ram;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [1:0]  md_a = 0, md_b = 0;
  logic [5:0]  ad_a = 0, ad_b = 0;
  logic [15:0] wd_a = 0, wd_b = 0;
  logic [15:0] rd_a, rd_b;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [15:0] model [64];
  logic [15:0] last_a = 0, bq = 0, bp = 0;

  int          due_a[$], due_b[$];
  logic [15:0] exp_aq[$], exp_bq[$];
  string       tag_aq[$], tag_bq[$];

  tdp_ram #(.DEPTH(64), .WIDTH(16), .OUT_REG_A(1'b0), .OUT_REG_B(1'b1)) i_tdp_ram (
    .rst_ni(rst_n),
    .clk_a_i(clk), .en_a_i(en_a), .we_a_i(we_a), .wmode_a_i(md_a),
    .addr_a_i(ad_a), .wdata_a_i(wd_a), .rdata_a_o(rd_a),
    .clk_b_i(clk), .en_b_i(en_b), .we_b_i(we_b), .wmode_b_i(md_b),
    .addr_b_i(ad_b), .wdata_b_i(wd_b), .rdata_b_o(rd_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare queued expectations when due
  always @(negedge clk) begin
    while (due_a.size() > 0 && due_a[0] == cyc) begin
      void'(due_a.pop_front());
      chk({tag_aq.pop_front(), " port A"}, rd_a, exp_aq.pop_front());
    end
    while (due_b.size() > 0 && due_b[0] == cyc) begin
      void'(due_b.pop_front());
      chk({tag_bq.pop_front(), " port B"}, rd_b, exp_bq.pop_front());
    end
  end

  function automatic logic [15:0] rdw(input logic w, input logic [1:0] m,
                                      input logic [15:0] stored, input logic [15:0] wd,
                                      input logic [15:0] prev);
    if (!w)          return stored;
    if (m == 2'd0)   return stored;
    if (m == 2'd1)   return wd;
    return prev;
  endfunction

  // driver: one cycle on both ports, predicts outputs after the next edge
  task automatic op(input logic ea, input logic wa, input logic [1:0] ma,
                    input logic [5:0] aa, input logic [15:0] da,
                    input logic eb, input logic wb, input logic [1:0] mb,
                    input logic [5:0] ab, input logic [15:0] db,
                    input bit ca, input bit cb, input string tag);
    logic [15:0] ea_v, nb, eb_v;
    @(negedge clk);
    en_a = ea; we_a = wa; md_a = ma; ad_a = aa; wd_a = da;
    en_b = eb; we_b = wb; md_b = mb; ad_b = ab; wd_b = db;
    ea_v = ea ? rdw(wa, ma, model[aa], da, last_a) : last_a;
    nb   = eb ? rdw(wb, mb, model[ab], db, bq) : bq;
    eb_v = eb ? bq : bp;
    if (eb) begin bp = bq; bq = nb; end
    last_a = ea_v;
    if (eb && wb && !(ea && wa && aa == ab)) model[ab] = db;
    if (ea && wa) model[aa] = da;
    if (ca && !$isunknown(ea_v)) begin
      due_a.push_back(cyc + 1); exp_aq.push_back(ea_v); tag_aq.push_back(tag);
    end
    if (cb && !$isunknown(eb_v)) begin
      due_b.push_back(cyc + 1); exp_bq.push_back(eb_v); tag_bq.push_back(tag);
    end
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset A", rd_a, 16'h0000);
    chk("R1 reset B", rd_b, 16'h0000);
    rst_n = 1'b1;

    // R5 new-data writes on A, B writes upper half in old-data mode
    for (int i = 0; i < 8; i++)
      op(1, 1, 2'd1, 6'(i), 16'hA000 + 16'(i), 1, 1, 2'd0, 6'(32 + i), 16'hB000 + 16'(i), 1, 0, "R5");
    // R8 cross reads, R2 and R7 on the pipelined port B
    for (int i = 0; i < 8; i++)
      op(1, 0, 2'd0, 6'(32 + i), 0, 1, 0, 2'd0, 6'(i), 0, 1, 1, "R8 R2 R7");
    op(1, 0, 2'd0, 6'(33), 0, 1, 0, 2'd0, 6'(7), 0, 1, 1, "R7");
    // R4 old-data write on A, then read back on B
    op(1, 1, 2'd0, 6'(3), 16'h1234, 1, 0, 2'd0, 6'(20), 0, 1, 0, "R4");
    op(1, 0, 2'd0, 6'(3), 0, 1, 0, 2'd0, 6'(3), 0, 1, 1, "R4");
    op(1, 0, 2'd0, 6'(2), 0, 1, 0, 2'd0, 6'(3), 0, 1, 1, "R4");
    // R6 hold modes on both ports
    op(1, 1, 2'd2, 6'(4), 16'h5555, 1, 1, 2'd2, 6'(40), 16'h7777, 1, 1, "R6");
    op(1, 1, 2'd3, 6'(5), 16'h6666, 1, 1, 2'd3, 6'(41), 16'h8888, 1, 1, "R6");
    op(1, 0, 2'd0, 6'(40), 0, 1, 0, 2'd0, 6'(4), 0, 1, 1, "R6");
    op(1, 0, 2'd0, 6'(41), 0, 1, 0, 2'd0, 6'(5), 0, 1, 1, "R6");
    op(1, 0, 2'd0, 6'(0), 0, 1, 0, 2'd0, 6'(0), 0, 1, 1, "R6");
    // R3 disabled ports with write enable set: no write, frozen outputs
    op(0, 1, 2'd1, 6'(6), 16'hFFFF, 0, 1, 2'd1, 6'(7), 16'hEEEE, 1, 1, "R3");
    op(0, 1, 2'd1, 6'(6), 16'hFFFF, 0, 1, 2'd1, 6'(7), 16'hEEEE, 1, 1, "R3");
    op(1, 0, 2'd0, 6'(6), 0, 1, 0, 2'd0, 6'(7), 0, 1, 1, "R3");
    op(1, 0, 2'd0, 6'(7), 0, 1, 0, 2'd0, 6'(6), 0, 1, 1, "R3");
    op(1, 0, 2'd0, 6'(7), 0, 1, 0, 2'd0, 6'(6), 0, 1, 1, "R3");
    // R9 same-address writes on a shared edge; outputs not checked that cycle
    op(1, 1, 2'd1, 6'(9), 16'h1111, 1, 1, 2'd1, 6'(9), 16'h2222, 0, 0, "R9");
    op(1, 0, 2'd0, 6'(9), 0, 1, 0, 2'd0, 6'(9), 0, 1, 0, "R9");
    op(1, 0, 2'd0, 6'(9), 0, 1, 0, 2'd0, 6'(9), 0, 1, 0, "R9");
    op(1, 0, 2'd0, 6'(9), 0, 1, 0, 2'd0, 6'(9), 0, 1, 1, "R9");
    idle();
    idle();

    // R1 reset mid-run keeps memory
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid reset A", rd_a, 16'h0000);
    chk("R1 mid reset B", rd_b, 16'h0000);
    last_a = 0; bq = 0; bp = 0;
    @(negedge clk);
    rst_n = 1'b1;
    op(1, 0, 2'd0, 6'(0), 0, 1, 0, 2'd0, 6'(1), 0, 1, 1, "R1");
    op(1, 0, 2'd0, 6'(1), 0, 1, 0, 2'd0, 6'(1), 0, 1, 1, "R1");
    idle();
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule